// File: doc/BRIEF.md
# Fuse-Programmable Logic Array

This block is a sum-of-products logic array whose personality is held in on-chip registers rather than in a mask. After reset a configuration stream is clocked in one bit per strobed cycle. The stream sets up three things: the literal selections of every product term, the connection of each term to the outputs, and one inversion bit per output. When the last bit has been taken, the array turns live. From then on its output vector is a purely combinational function of its input vector.

The numbers of inputs (1 to 32), outputs (1 to 32) and product terms (1 to 512) are parameters. A 16-input, 8-output, 48-term array and a 27-input, 18-output, 48-term array are both ordinary settings. A system normally streams the personality in once after reset and then uses the array as address-decode or glue logic. Asserting reset again discards the personality so that a new one can be loaded.

Top module: `fpla_top`

## Requirements
- R1: The stream is taken term by term, from term 0 upward. Within a term it carries, for each input in ascending order, the complement-literal fuse and then the true-literal fuse. The term's output-link fuses follow, one per output in ascending order. With S = 2*N_IN + N_OUT, the complement fuse of term t, input i is stream bit t*S + 2*i, the true fuse is bit t*S + 2*i + 1, and the link fuse of output o is bit t*S + 2*N_IN + o.
- R2: One polarity fuse per output, in ascending output order, follows the last term at stream bit N_TERM*S + o. `load_done` is 0 until exactly N_TERM*S + N_OUT bits have been accepted on rising clock edges with `fuse_valid` high. It is 1 right after the edge that accepts the last of them.
- R3: A true-literal fuse of 0 makes the term require that input to be 1, and a complement-literal fuse of 0 makes it require the input to be 0. A fuse of 1 leaves that literal out of the term.
- R4: A term whose true and complement fuses are both 0 for any one input is never active.
- R5: A link fuse of 0 connects the term to that output, and a link fuse of 1 leaves the output unaffected by that term.
- R6: Each output is the OR of all active terms connected to it, XORed with that output's polarity fuse, so a polarity fuse of 1 inverts the output.
- R7: While `load_done` is 0, every output bit is 0 whatever the inputs are.
- R8: Once `load_done` is 1, further strobed bits change neither `load_done` nor the input-to-output function.
- R9: Reset clears `load_done` and restarts the stream at bit 0, so a following load fully replaces the earlier personality.
- R10: Once loaded, outputs follow an input change within the same cycle with no clock edge, and they stay constant while the inputs are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration load |
| rst_n | input | 1 | Active-low synchronous reset of the load sequencer |
| fuse_valid | input | 1 | Strobe: `fuse_bit` is taken on this rising edge |
| fuse_bit | input | 1 | Next configuration bit in stream order |
| load_done | output | 1 | Personality fully loaded and array live |
| in_vec | input | N_IN | Array inputs |
| out_vec | output | N_OUT | Array outputs |

## Verification
The bench builds the array with 4 inputs, 3 outputs and 4 terms, so the stream is only 47 bits long. With that size, a hand-built personality can be checked against all sixteen input patterns. That personality contains a term whose two fuses for one input are both cleared, a term left out of most outputs, and an inverted output. The small size also makes it cheap to reload several random personalities after reset and compare each one against an independent evaluation model. The boundary between the second-to-last and the last stream bit falls inside a short run, as do the overrun bits sent after loading.

// File: rtl/fpla_pkg.sv
package fpla_pkg;

   typedef enum logic [1:0] {
      PH_AND  = 2'd0,
      PH_OR   = 2'd1,
      PH_POL  = 2'd2,
      PH_DONE = 2'd3
   } fpla_phase_e;

   function automatic int fpla_idx_w(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/fpla_fuse_loader.sv
module fpla_fuse_loader
   import fpla_pkg::*;
#(
   parameter int N_IN   = 16,
   parameter int N_OUT  = 8,
   parameter int N_TERM = 48
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              fuse_valid,
   input  logic                              fuse_bit,
   output logic                              load_done,
   output logic [N_TERM-1:0][N_IN-1:0]       lit_true,
   output logic [N_TERM-1:0][N_IN-1:0]       lit_comp,
   output logic [N_TERM-1:0][N_OUT-1:0]      link,
   output logic [N_OUT-1:0]                  polarity
);

   localparam int IW = fpla_idx_w(N_IN);
   localparam int OW = fpla_idx_w(N_OUT);
   localparam int TW = fpla_idx_w(N_TERM);
   localparam logic [IW-1:0] I_LAST = IW'(N_IN - 1);
   localparam logic [OW-1:0] O_LAST = OW'(N_OUT - 1);
   localparam logic [TW-1:0] T_LAST = TW'(N_TERM - 1);

   fpla_phase_e     phase_q;
   logic [TW-1:0]   term_q;
   logic [IW-1:0]   in_q;
   logic [OW-1:0]   out_q;
   logic            lit_q;   // 0: complement fuse next, 1: true fuse next
   logic            take;

   assign take      = fuse_valid && (phase_q != PH_DONE);
   assign load_done = (phase_q == PH_DONE);

   // stream position sequencer
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_AND;
         term_q  <= '0;
         in_q    <= '0;
         out_q   <= '0;
         lit_q   <= 1'b0;
      end else if (take) begin
         unique case (phase_q)
            PH_AND: begin
               lit_q <= ~lit_q;
               if (lit_q) begin
                  if (in_q == I_LAST) begin
                     in_q    <= '0;
                     phase_q <= PH_OR;
                  end else begin
                     in_q <= in_q + 1'b1;
                  end
               end
            end
            PH_OR: begin
               if (out_q == O_LAST) begin
                  out_q <= '0;
                  if (term_q == T_LAST) begin
                     term_q  <= '0;
                     phase_q <= PH_POL;
                  end else begin
                     term_q  <= term_q + 1'b1;
                     phase_q <= PH_AND;
                  end
               end else begin
                  out_q <= out_q + 1'b1;
               end
            end
            PH_POL: begin
               if (out_q == O_LAST) begin
                  out_q   <= '0;
                  phase_q <= PH_DONE;
               end else begin
                  out_q <= out_q + 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

   // fuse storage: no reset, outputs are gated until the array is loaded
   always_ff @(posedge clk) begin
      if (take) begin
         unique case (phase_q)
            PH_AND: begin
               if (lit_q) lit_true[term_q][in_q] <= fuse_bit;
               else       lit_comp[term_q][in_q] <= fuse_bit;
            end
            PH_OR:   link[term_q][out_q] <= ~fuse_bit;  // stored as connect flag
            PH_POL:  polarity[out_q]     <= fuse_bit;
            default: ;
         endcase
      end
   end

   // R8
   // loaded state is sticky until reset
   done_sticky_chk : assert property (@(posedge clk) disable iff (!rst_n)
      load_done |=> load_done);

   // R2
   // completion only follows an accepted bit
   done_cause_chk : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(load_done) |-> $past(fuse_valid));

   // R1
   // sequencer never leaves the index ranges
   index_range_chk : assert property (@(posedge clk) disable iff (!rst_n)
      (term_q <= T_LAST) && (in_q <= I_LAST) && (out_q <= O_LAST));

endmodule

// File: rtl/fpla_and_plane.sv
module fpla_and_plane #(
   parameter int N_IN   = 16,
   parameter int N_TERM = 48
) (
   input  logic [N_IN-1:0]                 in_vec,
   input  logic [N_TERM-1:0][N_IN-1:0]     lit_true,
   input  logic [N_TERM-1:0][N_IN-1:0]     lit_comp,
   output logic [N_TERM-1:0]               active
);

   for (genvar t = 0; t < N_TERM; t++) begin : g_term
      logic [N_IN-1:0] lit_ok;
      for (genvar i = 0; i < N_IN; i++) begin : g_lit
         assign lit_ok[i] = (lit_true[t][i] | in_vec[i]) & (lit_comp[t][i] | ~in_vec[i]);
      end
      assign active[t] = &lit_ok;
   end

endmodule

// File: rtl/fpla_or_plane.sv
module fpla_or_plane #(
   parameter int N_OUT  = 8,
   parameter int N_TERM = 48
) (
   input  logic                            enable,
   input  logic [N_TERM-1:0]               active,
   input  logic [N_TERM-1:0][N_OUT-1:0]    link,
   input  logic [N_OUT-1:0]                polarity,
   output logic [N_OUT-1:0]                out_vec
);

   for (genvar o = 0; o < N_OUT; o++) begin : g_out
      logic [N_TERM-1:0] column;
      always_comb begin
         for (int t = 0; t < N_TERM; t++) column[t] = link[t][o];
      end
      assign out_vec[o] = enable & ((|(active & column)) ^ polarity[o]);
   end

endmodule

// File: rtl/fpla_top.sv
module fpla_top
   import fpla_pkg::*;
#(
   parameter int N_IN   = 16,
   parameter int N_OUT  = 8,
   parameter int N_TERM = 48
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fuse_valid,
   input  logic              fuse_bit,
   output logic              load_done,
   input  logic [N_IN-1:0]   in_vec,
   output logic [N_OUT-1:0]  out_vec
);

   if (N_IN < 1 || N_IN > 32) begin : g_bad_in
      $error("fpla_top: N_IN must lie in 1..32");
   end
   if (N_OUT < 1 || N_OUT > 32) begin : g_bad_out
      $error("fpla_top: N_OUT must lie in 1..32");
   end
   if (N_TERM < 1 || N_TERM > 512) begin : g_bad_term
      $error("fpla_top: N_TERM must lie in 1..512");
   end

   logic [N_TERM-1:0][N_IN-1:0]  lit_true;
   logic [N_TERM-1:0][N_IN-1:0]  lit_comp;
   logic [N_TERM-1:0][N_OUT-1:0] link;
   logic [N_OUT-1:0]             polarity;
   logic [N_TERM-1:0]            active;

   fpla_fuse_loader #(.N_IN(N_IN), .N_OUT(N_OUT), .N_TERM(N_TERM)) u_loader (
      .clk        (clk),
      .rst_n      (rst_n),
      .fuse_valid (fuse_valid),
      .fuse_bit   (fuse_bit),
      .load_done  (load_done),
      .lit_true   (lit_true),
      .lit_comp   (lit_comp),
      .link       (link),
      .polarity   (polarity)
   );

   fpla_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) u_and (
      .in_vec   (in_vec),
      .lit_true (lit_true),
      .lit_comp (lit_comp),
      .active   (active)
   );

   fpla_or_plane #(.N_OUT(N_OUT), .N_TERM(N_TERM)) u_or (
      .enable   (load_done),
      .active   (active),
      .link     (link),
      .polarity (polarity),
      .out_vec  (out_vec)
   );

   // R7
   idle_zero_chk : assert property (@(posedge clk) disable iff (!rst_n)
      !load_done |-> (out_vec == '0));

   // R10
   hold_stable_chk : assert property (@(posedge clk) disable iff (!rst_n)
      ($past(load_done) && load_done && $stable(in_vec)) |-> $stable(out_vec));

endmodule

// File: tb/fpla_top_tb.sv
module fpla_top_tb;

   localparam int N  = 4;
   localparam int M  = 3;
   localparam int T  = 4;
   localparam int S  = 2 * N + M;
   localparam int NF = T * S + M;

   // {in_vec[3:0], expected out_vec[2:0]} for the directed personality
   localparam logic [6:0] VEC [16] = '{
      {4'd0,  3'b110}, {4'd1,  3'b111}, {4'd2,  3'b110}, {4'd3,  3'b110},
      {4'd4,  3'b101}, {4'd5,  3'b101}, {4'd6,  3'b101}, {4'd7,  3'b101},
      {4'd8,  3'b010}, {4'd9,  3'b011}, {4'd10, 3'b010}, {4'd11, 3'b010},
      {4'd12, 3'b001}, {4'd13, 3'b001}, {4'd14, 3'b001}, {4'd15, 3'b001}
   };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         fuse_valid = 1'b0;
   logic         fuse_bit = 1'b0;
   logic         load_done;
   logic [N-1:0] in_vec = '0;
   logic [M-1:0] out_vec;

   int  n_cmp = 0;
   int  n_bad = 0;
   bit  finished = 1'b0;

   always #5 clk = ~clk;

   fpla_top #(.N_IN(N), .N_OUT(M), .N_TERM(T)) u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .fuse_valid (fuse_valid),
      .fuse_bit   (fuse_bit),
      .load_done  (load_done),
      .in_vec     (in_vec),
      .out_vec    (out_vec)
   );

   function automatic int f_comp(int t, int i); return t * S + 2 * i;     endfunction
   function automatic int f_true(int t, int i); return t * S + 2 * i + 1; endfunction
   function automatic int f_link(int t, int o); return t * S + 2 * N + o; endfunction
   function automatic int f_pol(int o);         return T * S + o;         endfunction

   // independent evaluation model
   function automatic logic [M-1:0] model(logic [NF-1:0] mp, logic [N-1:0] x);
      logic [M-1:0] acc = '0;
      for (int t = 0; t < T; t++) begin
         bit hit = 1'b1;
         for (int i = 0; i < N; i++) begin
            if (!mp[f_true(t, i)] && !x[i]) hit = 1'b0;
            if (!mp[f_comp(t, i)] &&  x[i]) hit = 1'b0;
         end
         if (hit)
            for (int o = 0; o < M; o++) if (!mp[f_link(t, o)]) acc[o] = 1'b1;
      end
      for (int o = 0; o < M; o++) acc[o] = acc[o] ^ mp[f_pol(o)];
      return acc;
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk) rst_n = 1'b0;
      fuse_valid = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic send_range(logic [NF-1:0] mp, int lo, int hi);
      for (int k = lo; k < hi; k++) begin
         @(negedge clk) fuse_valid = 1'b1;
         fuse_bit = mp[k];
      end
      @(negedge clk) fuse_valid = 1'b0;
   endtask

   task automatic run_table(string req);
      for (int v = 0; v < 16; v++) begin
         in_vec = VEC[v][6:3];
         #1;
         chk(req, 32'(out_vec), 32'(VEC[v][2:0]));
      end
   endtask

   logic [NF-1:0] dmap;

   initial begin
      // directed personality
      dmap = '1;
      for (int o = 0; o < M; o++) dmap[f_pol(o)] = 1'b0;
      dmap[f_true(0, 0)] = 1'b0; dmap[f_comp(0, 1)] = 1'b0; dmap[f_link(0, 0)] = 1'b0;
      dmap[f_true(1, 2)] = 1'b0; dmap[f_link(1, 0)] = 1'b0; dmap[f_link(1, 1)] = 1'b0;
      dmap[f_true(2, 3)] = 1'b0; dmap[f_comp(2, 3)] = 1'b0; dmap[f_link(2, 2)] = 1'b0;
      dmap[f_comp(3, 3)] = 1'b0; dmap[f_link(3, 2)] = 1'b0;
      dmap[f_pol(1)] = 1'b1;

      do_reset();
      #1;
      chk("R9 reset load_done", 32'(load_done), 32'd0);
      chk("R7 reset outputs", 32'(out_vec), 32'd0);

      // all but the last bit
      send_range(dmap, 0, NF - 1);
      chk("R2 done before last bit", 32'(load_done), 32'd0);
      for (int v = 0; v < 16; v += 5) begin
         in_vec = 4'(v);
         #1;
         chk("R7 outputs idle during load", 32'(out_vec), 32'd0);
      end
      send_range(dmap, NF - 1, NF);
      chk("R2 done after last bit", 32'(load_done), 32'd1);

      // R1 R3 R4 R5 R6: exhaustive table
      run_table("R6 directed table");

      // R10: change inputs with no clock edge in between
      @(posedge clk) #2;
      in_vec = 4'd4;
      #1 chk("R10 same-cycle change a", 32'(out_vec), 32'b101);
      in_vec = 4'd9;
      #1 chk("R10 same-cycle change b", 32'(out_vec), 32'b011);
      in_vec = 4'd3;
      #1 chk("R4 contradictory term stays off", 32'(out_vec[2]), 32'd1);

      // R8: overrun bits of zero would link everything if accepted
      send_range('0, 0, 12);
      chk("R8 done after overrun", 32'(load_done), 32'd1);
      run_table("R8 function after overrun");

      // R9: reset then random personalities against the model
      for (int r = 0; r < 4; r++) begin
         logic [NF-1:0] rmap;
         for (int t = 0; t < T; t++) begin
            for (int i = 0; i < N; i++) begin
               rmap[f_comp(t, i)] = ($urandom % 4) != 0;
               rmap[f_true(t, i)] = ($urandom % 4) != 0;
            end
            for (int o = 0; o < M; o++) rmap[f_link(t, o)] = $urandom % 2;
         end
         for (int o = 0; o < M; o++) rmap[f_pol(o)] = $urandom % 2;
         do_reset();
         #1 chk("R9 reset clears done", 32'(load_done), 32'd0);
         send_range(rmap, 0, NF);
         chk("R2 done after reload", 32'(load_done), 32'd1);
         for (int v = 0; v < 16; v++) begin
            in_vec = 4'(v);
            #1 chk("R9 reload matches model", 32'(out_vec), 32'(model(rmap, in_vec)));
         end
      end

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!finished) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog (all requirements) actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule